// File: doc/BRIEF.md
# DMA Page Translation Unit

This block stands between DMA masters and the system bus. A master presents a 24-bit device address, a write flag and the number of address bits it can drive. The block looks up one of 2048 page descriptors, each covering 8 KB, and returns a 32-bit system bus address. With it come the cache-inhibit and full-block attributes of the page and a bus request strobe. A lookup that must not proceed raises exactly one fault flag, and the bus request strobe stays low.

The descriptor table sits in on-chip storage. The CPU reads and writes whole 32-bit descriptors through a simple indexed port. A lookup is registered: the result and a done strobe appear one clock after the request. After reset every descriptor reads as unmapped, so all DMA traffic faults until software fills the table.

Top module: `dxl_xlate`

## Requirements
- R1: After reset every descriptor reads back as 32'h0 on the CPU port, and every DMA lookup raises the unmapped fault until that descriptor is written.
- R2: `dma_done` is high exactly in the cycle after a cycle with `dma_req` high. The lookup uses address bits 23..13 as the descriptor index.
- R3: A descriptor whose type field (bits 1..0) is 2'b01 gives a successful translation. `dma_bus_req` is high, no fault flag is set, and `dma_sys_addr` is descriptor bits 31..13 joined with device address bits 12..0.
- R4: Type 2'b00 raises `dma_fault_unmapped`, and `dma_bus_req` stays low.
- R5: Types 2'b10 and 2'b11 raise `dma_fault_bad`, and `dma_bus_req` stays low. Type 2'b11 must not be taken as valid.
- R6: A DMA write to a valid page whose write-protect bit (bit 2) is set raises `dma_fault_wprot` with no bus request. A DMA read of the same page succeeds.
- R7: For a device width N below 24, address bits N and above are forced to one before the lookup. N of 24 or more leaves the address unchanged.
- R8: On success, `dma_ci` is descriptor bit 6 and `dma_bx` is descriptor bit 5. On any fault, `dma_ci`, `dma_bx` and `dma_sys_addr` are all zero.
- R9: A CPU write stores all 32 bits. A CPU read returns the stored word with `cpu_rvalid` one clock after `cpu_re`.
- R10: If a CPU write and a DMA lookup address the same descriptor in the same cycle, the lookup sees the old contents.
- R11: At most one fault flag is high at a time. A malformed type takes precedence over write protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Descriptor write strobe |
| cpu_re | input | 1 | Descriptor read strobe |
| cpu_idx | input | 11 | Descriptor index for read or write |
| cpu_wdata | input | 32 | Descriptor write data |
| cpu_rdata | output | 32 | Descriptor read data |
| cpu_rvalid | output | 1 | Read data valid, one clock after `cpu_re` |
| dma_req | input | 1 | Lookup request |
| dma_addr | input | 24 | Device DMA address |
| dma_wr | input | 1 | Request is a write |
| dma_width | input | 5 | Number of address bits the device drives |
| dma_done | output | 1 | Lookup result valid |
| dma_sys_addr | output | 32 | Translated system bus address |
| dma_bus_req | output | 1 | Translation succeeded; the system bus access may start |
| dma_ci | output | 1 | Cache-inhibit attribute of the page |
| dma_bx | output | 1 | Full-block-transfer attribute of the page |
| dma_fault_unmapped | output | 1 | Page descriptor is unmapped |
| dma_fault_bad | output | 1 | Page descriptor has a malformed type |
| dma_fault_wprot | output | 1 | Write refused by write protection |

## Verification
A stale or corrupted written-mask bit, or a misrouted index, shows up at the ports on the very next lookup of the affected page: the wrong fault flag, or a successful translation carrying the wrong page frame. Because every result comes exactly one clock after its request, the scoreboard pairs each done strobe with one predicted item, so a dropped, duplicated or delayed result is caught at once. The width-forcing and same-cycle collision cases are aimed at pages that differ from their neighbours, so a wrong index or the wrong read ordering always changes the observed result.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

  // Descriptor type codes (bits 1..0 of a descriptor)
  typedef enum logic [1:0] {
    KIND_EMPTY = 2'b00,
    KIND_LIVE  = 2'b01,
    KIND_BADA  = 2'b10,
    KIND_BADB  = 2'b11
  } kind_e;

  // Attribute bit positions inside a descriptor
  localparam int POS_CI = 6;
  localparam int POS_BX = 5;
  localparam int POS_WP = 2;

  typedef struct packed {
    logic unmapped;
    logic bad;
    logic wprot;
  } fault_t;

endpackage

// File: rtl/dxl_widen.sv
module dxl_widen #(
  parameter int AW = 24,
  parameter int WW = 5
) (
  input  logic [AW-1:0] addr_i,
  input  logic [WW-1:0] width_i,
  output logic [AW-1:0] addr_o
);

  // Bits at or above the device width are forced high (flush to top of space)
  for (genvar g = 0; g < AW; g++) begin : g_bit
    localparam int BITI = g;
    assign addr_o[g] = addr_i[g] | (BITI >= int'(width_i));
  end

endmodule

// File: rtl/dxl_table.sv
module dxl_table #(
  parameter int ENTRIES = 2048,
  parameter int IDX_W   = 11,
  parameter int DW      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic             cpu_rd_en,
  input  logic [IDX_W-1:0] cpu_rd_idx,
  output logic [DW-1:0]    cpu_rd_data,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  output logic [DW-1:0]    lk_desc
);

  logic [DW-1:0]      mem [ENTRIES];
  logic [ENTRIES-1:0] written_q, written_d;
  logic [DW-1:0]      lk_raw_q, cpu_raw_q;
  logic               lk_live_q, lk_live_d;
  logic               cpu_live_q, cpu_live_d;

  // Next state: written mask and read-side live bits
  always_comb begin
    written_d = written_q;
    if (wr_en) written_d[wr_idx] = 1'b1;
    lk_live_d  = lk_en     ? written_q[lk_idx]     : lk_live_q;
    cpu_live_d = cpu_rd_en ? written_q[cpu_rd_idx] : cpu_live_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written_q  <= '0;
      lk_live_q  <= 1'b0;
      cpu_live_q <= 1'b0;
    end else begin
      written_q  <= written_d;
      lk_live_q  <= lk_live_d;
      cpu_live_q <= cpu_live_d;
    end
  end

  // Storage array carries no reset; the written mask stands in for it
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // Registered reads sample before this edge's write lands
  always_ff @(posedge clk) begin
    if (lk_en)     lk_raw_q  <= mem[lk_idx];
    if (cpu_rd_en) cpu_raw_q <= mem[cpu_rd_idx];
  end

  assign lk_desc     = lk_live_q  ? lk_raw_q  : '0;
  assign cpu_rd_data = cpu_live_q ? cpu_raw_q : '0;

  p_unwritten_reads_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && !written_q[lk_idx]) |=> (lk_desc == '0));

  // R10: a same-cycle write to an unwritten entry is not visible to the lookup
  p_collision_sees_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_en && wr_en && (wr_idx == lk_idx) && !written_q[lk_idx]) |=> (lk_desc == '0));

endmodule

// File: rtl/dxl_check.sv
module dxl_check
  import dxl_pkg::*;
#(
  parameter int DW   = 32,
  parameter int OFFW = 13
) (
  input  logic            done_i,
  input  logic            wr_i,
  input  logic [DW-1:0]   desc_i,
  input  logic [OFFW-1:0] off_i,
  output fault_t          fault_o,
  output logic            ok_o,
  output logic [DW-1:0]   sys_addr_o,
  output logic            ci_o,
  output logic            bx_o
);

  kind_e kind;
  logic  wp_hit;
  logic  unused_bits;

  assign kind        = kind_e'(desc_i[1:0]);
  assign wp_hit      = wr_i & desc_i[POS_WP];
  assign unused_bits = ^desc_i[OFFW-1:7] ^ desc_i[4] ^ desc_i[3];

  always_comb begin
    fault_o = '0;
    ok_o    = 1'b0;
    if (done_i) begin
      unique case (kind)
        KIND_EMPTY:         fault_o.unmapped = 1'b1;
        KIND_BADA, KIND_BADB: fault_o.bad    = 1'b1;
        KIND_LIVE: begin
          fault_o.wprot = wp_hit;
          ok_o          = ~wp_hit;
        end
        default:            fault_o.bad      = 1'b1;
      endcase
    end
  end

  assign sys_addr_o = ok_o ? {desc_i[DW-1:OFFW], off_i} : '0;
  assign ci_o       = ok_o & desc_i[POS_CI];
  assign bx_o       = ok_o & desc_i[POS_BX];

endmodule

// File: rtl/dxl_xlate.sv
module dxl_xlate
  import dxl_pkg::*;
#(
  parameter int DMA_AW     = 24,
  parameter int SYS_AW     = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int WIDTH_W    = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_we,
  input  logic                  cpu_re,
  input  logic [DMA_AW-PAGE_SHIFT-1:0] cpu_idx,
  input  logic [SYS_AW-1:0]     cpu_wdata,
  output logic [SYS_AW-1:0]     cpu_rdata,
  output logic                  cpu_rvalid,
  input  logic                  dma_req,
  input  logic [DMA_AW-1:0]     dma_addr,
  input  logic                  dma_wr,
  input  logic [WIDTH_W-1:0]    dma_width,
  output logic                  dma_done,
  output logic [SYS_AW-1:0]     dma_sys_addr,
  output logic                  dma_bus_req,
  output logic                  dma_ci,
  output logic                  dma_bx,
  output logic                  dma_fault_unmapped,
  output logic                  dma_fault_bad,
  output logic                  dma_fault_wprot
);

  localparam int IDX_W   = DMA_AW - PAGE_SHIFT;
  localparam int ENTRIES = 1 << IDX_W;

  logic [DMA_AW-1:0]     eff_addr;
  logic [SYS_AW-1:0]     lk_desc;
  logic                  req_q, req_d;
  logic                  wr_q, wr_d;
  logic [PAGE_SHIFT-1:0] off_q, off_d;
  logic                  rv_q, rv_d;
  fault_t                fault;

  dxl_widen #(.AW(DMA_AW), .WW(WIDTH_W)) u_widen (
    .addr_i (dma_addr),
    .width_i(dma_width),
    .addr_o (eff_addr)
  );

  dxl_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .DW(SYS_AW)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cpu_we),
    .wr_idx     (cpu_idx),
    .wr_data    (cpu_wdata),
    .cpu_rd_en  (cpu_re),
    .cpu_rd_idx (cpu_idx),
    .cpu_rd_data(cpu_rdata),
    .lk_en      (dma_req),
    .lk_idx     (eff_addr[DMA_AW-1:PAGE_SHIFT]),
    .lk_desc    (lk_desc)
  );

  // Next state of the request pipeline stage
  always_comb begin
    req_d = dma_req;
    rv_d  = cpu_re;
    wr_d  = dma_req ? dma_wr : wr_q;
    off_d = dma_req ? eff_addr[PAGE_SHIFT-1:0] : off_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      wr_q  <= 1'b0;
      off_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      req_q <= req_d;
      wr_q  <= wr_d;
      off_q <= off_d;
      rv_q  <= rv_d;
    end
  end

  dxl_check #(.DW(SYS_AW), .OFFW(PAGE_SHIFT)) u_check (
    .done_i    (req_q),
    .wr_i      (wr_q),
    .desc_i    (lk_desc),
    .off_i     (off_q),
    .fault_o   (fault),
    .ok_o      (dma_bus_req),
    .sys_addr_o(dma_sys_addr),
    .ci_o      (dma_ci),
    .bx_o      (dma_bx)
  );

  assign dma_done           = req_q;
  assign cpu_rvalid         = rv_q;
  assign dma_fault_unmapped = fault.unmapped;
  assign dma_fault_bad      = fault.bad;
  assign dma_fault_wprot    = fault.wprot;

  p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> dma_done);

  p_no_stray_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |=> !dma_done);

  p_fault_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_fault_unmapped, dma_fault_bad, dma_fault_wprot}));

  p_quiet_on_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_fault_unmapped || dma_fault_bad || dma_fault_wprot)
      |-> (!dma_ci && !dma_bx && dma_sys_addr == '0 && !dma_bus_req));

  p_read_never_wprot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_wr) |=> !dma_fault_wprot);

  p_rvalid_follows_re_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_re |=> cpu_rvalid);

endmodule

// File: tb/test_dxl_xlate.sv
module test_dxl_xlate;

  typedef struct packed {
    logic [31:0] sys;
    logic        bus;
    logic        ci;
    logic        bx;
    logic        fu;
    logic        fb;
    logic        fw;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_we, cpu_re;
  logic [10:0] cpu_idx;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_rvalid;
  logic        dma_req, dma_wr;
  logic [23:0] dma_addr;
  logic [4:0]  dma_width;
  logic        dma_done, dma_bus_req, dma_ci, dma_bx;
  logic [31:0] dma_sys_addr;
  logic        dma_fault_unmapped, dma_fault_bad, dma_fault_wprot;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;
  logic [31:0] model [2048];
  item_t exp_q [$];
  string tag_q [$];

  always #5 clk = ~clk;

  dxl_xlate i_dxl_xlate (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_idx(cpu_idx),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .dma_req(dma_req), .dma_addr(dma_addr), .dma_wr(dma_wr), .dma_width(dma_width),
    .dma_done(dma_done), .dma_sys_addr(dma_sys_addr), .dma_bus_req(dma_bus_req),
    .dma_ci(dma_ci), .dma_bx(dma_bx),
    .dma_fault_unmapped(dma_fault_unmapped), .dma_fault_bad(dma_fault_bad),
    .dma_fault_wprot(dma_fault_wprot)
  );

  function automatic item_t predict(logic [23:0] a, logic wr, logic [4:0] w);
    item_t       it;
    logic [31:0] d;
    logic [23:0] e;
    e = a;
    for (int i = 0; i < 24; i++) if (i >= int'(w)) e[i] = 1'b1;  // R7
    d  = model[e[23:13]];
    it = '0;
    if (d[1])                    it.fb = 1'b1;          // R5
    else if (!d[0])              it.fu = 1'b1;          // R4
    else if (wr && d[2])         it.fw = 1'b1;          // R6
    else begin                                          // R3, R8
      it.bus = 1'b1;
      it.sys = {d[31:13], e[12:0]};
      it.ci  = d[6];
      it.bx  = d[5];
    end
    return it;
  endfunction

  task automatic lookup(logic [23:0] a, logic wr, logic [4:0] w, string tag);
    @(negedge clk);
    dma_req = 1'b1; dma_addr = a; dma_wr = wr; dma_width = w;
    exp_q.push_back(predict(a, wr, w));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    dma_req = 1'b0; cpu_we = 1'b0; cpu_re = 1'b0;
  endtask

  task automatic cpu_write(logic [10:0] idx, logic [31:0] v);
    @(negedge clk);
    dma_req = 1'b0;
    cpu_we = 1'b1; cpu_idx = idx; cpu_wdata = v;
    model[idx] = v;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  // Lookup and CPU write in the same cycle; prediction uses the old entry
  task automatic collide(logic [23:0] a, logic [31:0] v, string tag);
    @(negedge clk);
    dma_req = 1'b1; dma_addr = a; dma_wr = 1'b0; dma_width = 5'd24;
    exp_q.push_back(predict(a, 1'b0, 5'd24));
    tag_q.push_back(tag);
    cpu_we = 1'b1; cpu_idx = a[23:13]; cpu_wdata = v;
    model[a[23:13]] = v;
  endtask

  task automatic cpu_read(logic [10:0] idx, string tag);
    logic [31:0] e;
    @(negedge clk);
    dma_req = 1'b0;
    cpu_re = 1'b1; cpu_idx = idx;
    e = model[idx];
    @(negedge clk);
    cpu_re = 1'b0;
    n_checks++;
    if (cpu_rdata !== e || cpu_rvalid !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: cpu_rdata=%h rvalid=%b expected %h rvalid=1", tag, cpu_rdata, cpu_rvalid, e);
    end
  endtask

  // Monitor: compare every done strobe against the oldest prediction (R2)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished && dma_done === 1'b1) begin
      item_t got, exp;
      string t;
      got = {dma_sys_addr, dma_bus_req, dma_ci, dma_bx,
             dma_fault_unmapped, dma_fault_bad, dma_fault_wprot};
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2: unexpected done, got %h expected no result", got);
      end else begin
        exp = exp_q.pop_front();
        t   = tag_q.pop_front();
        if (got !== exp) begin
          n_fail++;
          $display("FAIL %s: got sys=%h bus=%b ci=%b bx=%b fu=%b fb=%b fw=%b expected sys=%h bus=%b ci=%b bx=%b fu=%b fb=%b fw=%b",
                   t, got.sys, got.bus, got.ci, got.bx, got.fu, got.fb, got.fw,
                   exp.sys, exp.bus, exp.ci, exp.bx, exp.fu, exp.fb, exp.fw);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2048; i++) model[i] = 32'h0;
    rst_n = 1'b0; cpu_we = 0; cpu_re = 0; cpu_idx = '0; cpu_wdata = '0;
    dma_req = 0; dma_addr = '0; dma_wr = 0; dma_width = 5'd24;
    repeat (3) @(negedge clk);
    n_checks++;
    if (dma_done !== 1'b0 || dma_bus_req !== 1'b0 || cpu_rvalid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: reset outputs done=%b bus=%b rvalid=%b expected 0 0 0", dma_done, dma_bus_req, cpu_rvalid);
    end
    rst_n = 1'b1;

    // R1: empty table
    cpu_read(11'd0, "R1 read idx0");
    cpu_read(11'd2047, "R1 read idx2047");
    lookup(24'h000000, 1'b0, 5'd24, "R1/R4 unmapped after reset");
    lookup(24'hFFFFFF, 1'b1, 5'd24, "R1 unmapped top page");
    idle();

    // R3/R8/R9: valid page with cache-inhibit, all bits readable
    cpu_write(11'd5, {19'h12345, 6'h2A, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01});
    cpu_read(11'd5, "R9 readback incl unused bits");
    lookup({11'd5, 13'h1ABC}, 1'b0, 5'd24, "R3 R8 valid read ci");
    lookup({11'd5, 13'h0001}, 1'b1, 5'd24, "R3 valid write b2b");
    // R8: full-block only
    cpu_write(11'd6, {19'h7FFFF, 6'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01});
    lookup({11'd6, 13'h1FFF}, 1'b1, 5'd24, "R8 bx only");
    // R4: type 00 with frame and attribute bits set
    cpu_write(11'd7, {19'h55555, 6'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00});
    lookup({11'd7, 13'h0010}, 1'b0, 5'd24, "R4 type00 unmapped");
    // R5: malformed codes
    cpu_write(11'd8, {19'h11111, 6'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'b10});
    cpu_write(11'd9, {19'h22222, 6'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11});
    lookup({11'd8, 13'h0}, 1'b0, 5'd24, "R5 type10 bad");
    lookup({11'd9, 13'h0}, 1'b0, 5'd24, "R5 type11 bad not valid");
    // R6: write protection
    cpu_write(11'd10, {19'h3ABCD, 6'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01});
    lookup({11'd10, 13'h0444}, 1'b1, 5'd24, "R6 write refused");
    lookup({11'd10, 13'h0444}, 1'b0, 5'd24, "R6 read allowed");
    // R11: malformed beats write-protect
    cpu_write(11'd11, {19'h0ABCD, 6'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11});
    lookup({11'd11, 13'h0}, 1'b1, 5'd24, "R11 bad over wprot");
    idle();

    // R7: narrow devices land at the top of the space
    cpu_write(11'h7F8, {19'h6D000, 6'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01});
    cpu_write(11'h780, {19'h0F0F0, 6'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01});
    cpu_write(11'h009, {19'h00009, 6'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01});
    lookup(24'h001234, 1'b0, 5'd16, "R7 width16");
    lookup(24'h000000, 1'b0, 5'd20, "R7 width20");
    lookup(24'h012345, 1'b0, 5'd24, "R7 width24 unchanged");
    lookup(24'h012345, 1'b0, 5'd31, "R7 width31 unchanged");
    lookup(24'h000005, 1'b0, 5'd0,  "R7 width0 all ones");
    idle();

    // R10: same-cycle write and lookup see old contents
    collide({11'd12, 13'h0100}, {19'h44444, 6'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b01},
            "R10 collide unwritten");
    idle();
    lookup({11'd12, 13'h0100}, 1'b0, 5'd24, "R10 after collide new");
    collide({11'd5, 13'h0002}, 32'h0, "R10 collide overwrite valid");
    idle();
    lookup({11'd5, 13'h0002}, 1'b0, 5'd24, "R10 after overwrite unmapped");
    cpu_read(11'd12, "R9 readback after collide");
    idle();
    repeat (3) @(negedge clk);

    n_checks++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    finish_run();
  end

endmodule